// File: doc/BRIEF.md
# Memory and Logic Power-Mode Controller

This block decides when the memories and the programmable logic of a peripheral may drop to low power. The host writes an 8-bit mode register. The block combines that register with the chip-select, the per-memory select decodes, the bus-width setting and the address LSB. From these it produces registered enables for the even and odd halves of a program memory and of a data memory. A "miser" control bit trades access readiness for lower current. When it is clear, the program memory stays powered for as long as the chip is selected. When it is set, a memory is powered only while it is the one being addressed. With the miser bit set and an 8-bit bus, only the half of the array that matches the address LSB is powered.

A second control bit switches the logic section out of turbo. With that bit set, the block watches a bus of logic inputs. If the bus holds still for a window counted in clock cycles, the block raises a low-power flag. Any change on the bus drops the flag and starts the count again.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: The mode register is 8 bits wide. It is written with `reg_wdata` at a clock edge where `reg_we` is 1, it is read back at all times on `reg_rdata`, and it holds 0x00 after reset. Only bit 3 (miser) and bit 4 (turbo-disable) change any output; the other bits are stored and have no effect.
- R2: With the miser bit at 0 and `cs_n` low, both program-memory half enables are 1, whatever `sel_prog` holds.
- R3: With `cs_n` high, all four memory half enables are 0, whatever the mode register holds.
- R4: With the miser bit at 1 and `cs_n` low, the program memory is powered only while `sel_prog` is 1; it is off when another memory is addressed or nothing is.
- R5: When the miser bit is 1, `bus8` is 1 and a memory is powered, only one of its halves is enabled. The even half is enabled when `addr0` is 0 and the odd half when `addr0` is 1. In every other case both halves follow the memory's on/off state.
- R6: The data memory is powered exactly when `cs_n` is low and `sel_data` is 1, whatever the miser bit holds; its halves follow R5.
- R7: Every output except `reg_rdata` is registered. An output reflects the inputs and the mode register as they were at the previous clock edge, and does not change between edges.
- R8: While `rst` is 1 at a clock edge, all four memory enables become 1, `logic_lowpwr` becomes 0 and the register is cleared.
- R9: With turbo-disable (bit 4) at 1, `logic_lowpwr` becomes 1 at the IDLE_CYCLES-th consecutive clock edge at which `logic_in` equals its value at the previous edge. It stays 1 while the bus stays unchanged.
- R10: If `logic_in` differs from its value at the previous edge, or turbo-disable is 0 at an edge, then `logic_lowpwr` is 0 after that edge and the idle count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip-select, active low |
| sel_prog | input | 1 | Program memory is being addressed |
| sel_data | input | 1 | Data memory is being addressed |
| bus8 | input | 1 | 1 selects the 8-bit data-bus mode |
| addr0 | input | 1 | Address LSB, picks the odd or even half |
| reg_we | input | 1 | Mode register write strobe |
| reg_wdata | input | 8 | Mode register write data |
| reg_rdata | output | 8 | Mode register readback |
| logic_in | input | IN_W | Monitored logic-section inputs |
| prog_en_even | output | 1 | Program memory even-half enable |
| prog_en_odd | output | 1 | Program memory odd-half enable |
| data_en_even | output | 1 | Data memory even-half enable |
| data_en_odd | output | 1 | Data memory odd-half enable |
| logic_lowpwr | output | 1 | Logic section in zero-power state |

## Verification
Random cycles sweep every combination of chip-select, miser bit, both selects, bus width and address LSB. This tells the miser-gated program memory apart from the always-gated data memory, and full-array enabling apart from half-array enabling. Mode writes with random values in the unused bits show that only bits 3 and 4 steer the outputs. Long runs of an unchanged logic bus, broken by single changes, separate an idle window that expires on the exact edge from one that expires early or late, and show that the count restarts after a change. Directed steps cover the reset values and show that an input change does not reach an output before the next edge.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  localparam int MODE_W    = 8;
  localparam int MISER_BIT = 3;
  localparam int TDIS_BIT  = 4;

  typedef logic [MODE_W-1:0] mode_t;

  typedef struct packed {
    logic even;
    logic odd;
  } half_en_t;
endpackage

// File: rtl/pmc_mode_reg.sv
module pmc_mode_reg
  import pwr_mode_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  we,
  input  mode_t wdata,
  output mode_t rdata,
  output logic  miser,
  output logic  tdis
);
  mode_t mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
    end else if (we) begin
      mode_q <= wdata;
    end
  end

  assign rdata = mode_q;
  assign miser = mode_q[MISER_BIT];
  assign tdis  = mode_q[TDIS_BIT];
endmodule

// File: rtl/pmc_mem_gate.sv
module pmc_mem_gate
  import pwr_mode_pkg::*;
#(
  parameter bit MISER_GATED = 1'b1
)(
  input  logic     clk,
  input  logic     rst,
  input  logic     cs_n,
  input  logic     sel,
  input  logic     miser,
  input  logic     bus8,
  input  logic     addr0,
  output half_en_t en
);
  logic     on;
  logic     split;
  half_en_t en_d;

  // MISER_GATED memories stay on while selected-chip and miser off;
  // the others are powered only while addressed.
  generate
    if (MISER_GATED) begin : g_miser
      assign on = !cs_n && (sel || !miser);
    end else begin : g_plain
      logic unused_miser;
      assign unused_miser = miser;
      assign on = !cs_n && sel;
    end
  endgenerate

  assign split     = miser && bus8;
  assign en_d.even = on && !(split && addr0);
  assign en_d.odd  = on && !(split && !addr0);

  always_ff @(posedge clk) begin
    if (rst) begin
      en <= '{even: 1'b1, odd: 1'b1};
    end else begin
      en <= en_d;
    end
  end
endmodule

// File: rtl/pmc_idle_timer.sv
module pmc_idle_timer #(
  parameter int IN_W        = 16,
  parameter int IDLE_CYCLES = 13
)(
  input  logic            clk,
  input  logic            rst,
  input  logic            tdis,
  input  logic [IN_W-1:0] din,
  output logic            lowpwr
);
  localparam int CW = $clog2(IDLE_CYCLES + 1);
  localparam logic [CW-1:0] LIM    = CW'(IDLE_CYCLES);
  localparam logic [CW-1:0] LIM_M1 = CW'(IDLE_CYCLES - 1);

  logic [IN_W-1:0] prev_q;
  logic [CW-1:0]   cnt_q;
  logic            chg;

  assign chg = (din != prev_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      cnt_q  <= '0;
      lowpwr <= 1'b0;
    end else begin
      prev_q <= din;
      if (chg || !tdis) begin
        cnt_q <= '0;
      end else if (cnt_q != LIM) begin
        cnt_q <= cnt_q + 1'b1;
      end
      lowpwr <= tdis && !chg && (cnt_q >= LIM_M1);
    end
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int IN_W        = 16,
  parameter int IDLE_CYCLES = 13
)(
  input  logic            clk,
  input  logic            rst,
  input  logic            cs_n,
  input  logic            sel_prog,
  input  logic            sel_data,
  input  logic            bus8,
  input  logic            addr0,
  input  logic            reg_we,
  input  logic [7:0]      reg_wdata,
  output logic [7:0]      reg_rdata,
  input  logic [IN_W-1:0] logic_in,
  output logic            prog_en_even,
  output logic            prog_en_odd,
  output logic            data_en_even,
  output logic            data_en_odd,
  output logic            logic_lowpwr
);
  logic     miser;
  logic     tdis;
  half_en_t prog_en;
  half_en_t data_en;

  pmc_mode_reg u_reg (
    .clk   (clk),
    .rst   (rst),
    .we    (reg_we),
    .wdata (reg_wdata),
    .rdata (reg_rdata),
    .miser (miser),
    .tdis  (tdis)
  );

  pmc_mem_gate #(.MISER_GATED(1'b1)) u_prog (
    .clk   (clk),
    .rst   (rst),
    .cs_n  (cs_n),
    .sel   (sel_prog),
    .miser (miser),
    .bus8  (bus8),
    .addr0 (addr0),
    .en    (prog_en)
  );

  pmc_mem_gate #(.MISER_GATED(1'b0)) u_data (
    .clk   (clk),
    .rst   (rst),
    .cs_n  (cs_n),
    .sel   (sel_data),
    .miser (miser),
    .bus8  (bus8),
    .addr0 (addr0),
    .en    (data_en)
  );

  pmc_idle_timer #(.IN_W(IN_W), .IDLE_CYCLES(IDLE_CYCLES)) u_idle (
    .clk    (clk),
    .rst    (rst),
    .tdis   (tdis),
    .din    (logic_in),
    .lowpwr (logic_lowpwr)
  );

  assign prog_en_even = prog_en.even;
  assign prog_en_odd  = prog_en.odd;
  assign data_en_even = data_en.even;
  assign data_en_odd  = data_en.odd;
endmodule

// File: rtl/pwr_mode_chk.sv
module pwr_mode_chk #(
  parameter int IN_W = 16
)(
  input logic            clk,
  input logic            rst,
  input logic            cs_n,
  input logic            sel_prog,
  input logic            bus8,
  input logic [7:0]      reg_rdata,
  input logic [IN_W-1:0] logic_in,
  input logic            prog_en_even,
  input logic            prog_en_odd,
  input logic            data_en_even,
  input logic            data_en_odd,
  input logic            logic_lowpwr
);
  p_cs_off_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cs_n)) |->
      !(prog_en_even || prog_en_odd || data_en_even || data_en_odd));

  p_miser_clear_on_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(!cs_n && !reg_rdata[3])) |->
      (prog_en_even && prog_en_odd));

  p_half_split_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(!cs_n && reg_rdata[3] && bus8 && sel_prog)) |->
      (prog_en_even != prog_en_odd));

  p_lowpwr_needs_tdis_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(reg_rdata[4])) |-> !logic_lowpwr);

  p_change_wakes_r10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && ($past(logic_in) != $past(logic_in, 2)))
      |-> !logic_lowpwr);
endmodule

bind pwr_mode_ctrl pwr_mode_chk #(.IN_W(IN_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cs_n         (cs_n),
  .sel_prog     (sel_prog),
  .bus8         (bus8),
  .reg_rdata    (reg_rdata),
  .logic_in     (logic_in),
  .prog_en_even (prog_en_even),
  .prog_en_odd  (prog_en_odd),
  .data_en_even (data_en_even),
  .data_en_odd  (data_en_odd),
  .logic_lowpwr (logic_lowpwr)
);

// File: tb/sim_pwr_mode_ctrl.sv
module sim_pwr_mode_ctrl;
  localparam int IN_W = 16;
  localparam int IDLE = 13;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic            rst, cs_n, sel_prog, sel_data, bus8, addr0, reg_we;
  logic [7:0]      reg_wdata, reg_rdata;
  logic [IN_W-1:0] logic_in;
  logic            prog_en_even, prog_en_odd, data_en_even, data_en_odd, logic_lowpwr;

  pwr_mode_ctrl #(.IN_W(IN_W), .IDLE_CYCLES(IDLE)) u0 (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sel_prog(sel_prog), .sel_data(sel_data),
    .bus8(bus8), .addr0(addr0), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .logic_in(logic_in), .prog_en_even(prog_en_even),
    .prog_en_odd(prog_en_odd), .data_en_even(data_en_even), .data_en_odd(data_en_odd),
    .logic_lowpwr(logic_lowpwr)
  );

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [7:0]      m_mode;
  logic [IN_W-1:0] m_prev;
  int              m_run;

  task automatic chk(string tag, string what, logic [7:0] got, logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s got=%0h exp=%0h", tag, what, got, exp);
    end
  endtask

  // Expected values come from the requirement rules applied to the bench's own model.
  task automatic step();
    logic p_on, d_on, split, e_pe, e_po, e_de, e_do, e_lp;
    string tp, td, tl;
    @(posedge clk);
    split = m_mode[3] && bus8;
    p_on  = !cs_n && (sel_prog || !m_mode[3]);
    d_on  = !cs_n && sel_data;
    e_pe  = p_on && !(split && addr0);
    e_po  = p_on && !(split && !addr0);
    e_de  = d_on && !(split && addr0);
    e_do  = d_on && !(split && !addr0);
    tp = cs_n ? "R3" : (split && p_on) ? "R5" : m_mode[3] ? "R4" : "R2";
    td = cs_n ? "R3" : (split && d_on) ? "R5" : "R6";
    if (m_mode[4] && logic_in == m_prev) begin
      m_run++;
      tl = "R9";
    end else begin
      m_run = 0;
      tl = "R10";
    end
    e_lp   = (m_run >= IDLE);
    m_prev = logic_in;
    if (reg_we) m_mode = reg_wdata;
    @(negedge clk);
    chk(tp, "prog_en_even", 8'(prog_en_even), 8'(e_pe));
    chk(tp, "prog_en_odd",  8'(prog_en_odd),  8'(e_po));
    chk(td, "data_en_even", 8'(data_en_even), 8'(e_de));
    chk(td, "data_en_odd",  8'(data_en_odd),  8'(e_do));
    chk(tl, "logic_lowpwr", 8'(logic_lowpwr), 8'(e_lp));
    chk("R1", "reg_rdata", reg_rdata, m_mode);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #1_200_000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst = 1'b1; cs_n = 1'b0; sel_prog = 1'b0; sel_data = 1'b0; bus8 = 1'b0;
    addr0 = 1'b0; reg_we = 1'b0; reg_wdata = 8'h00; logic_in = '0;
    m_mode = 8'h00; m_prev = '0; m_run = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8: reset state
    chk("R8", "prog_en_even", 8'(prog_en_even), 8'h1);
    chk("R8", "prog_en_odd",  8'(prog_en_odd),  8'h1);
    chk("R8", "data_en_even", 8'(data_en_even), 8'h1);
    chk("R8", "data_en_odd",  8'(data_en_odd),  8'h1);
    chk("R8", "logic_lowpwr", 8'(logic_lowpwr), 8'h0);
    chk("R1", "reset reg_rdata", reg_rdata, 8'h00);
    rst = 1'b0;

    // R2 then R7: change reaches outputs only after the next edge
    step();
    cs_n = 1'b1;
    #1;
    chk("R7", "prog_en_even before edge", 8'(prog_en_even), 8'h1);
    step();
    cs_n = 1'b0;

    // R9 / R10: miser + turbo-disable, hold bus still
    reg_we = 1'b1; reg_wdata = 8'h18; logic_in = 16'hA5A5;
    step();
    reg_we = 1'b0;
    repeat (IDLE + 3) step();
    chk("R9", "lowpwr after idle window", 8'(logic_lowpwr), 8'h1);
    logic_in = 16'hA5A4;
    step();
    chk("R10", "lowpwr after change", 8'(logic_lowpwr), 8'h0);
    repeat (IDLE - 2) step();
    chk("R10", "lowpwr restarted count", 8'(logic_lowpwr), 8'h0);

    // R1: unused bits only, miser and turbo-disable clear
    reg_we = 1'b1; reg_wdata = 8'hE7;
    step();
    reg_we = 1'b0; sel_prog = 1'b0; sel_data = 1'b0; bus8 = 1'b1; addr0 = 1'b1;
    step();
    chk("R1", "unused bits leave prog on", 8'(prog_en_even & prog_en_odd), 8'h1);

    // R5: miser with 8-bit bus, odd half
    reg_we = 1'b1; reg_wdata = 8'h08;
    step();
    reg_we = 1'b0; sel_prog = 1'b1;
    step();
    chk("R5", "odd half only", {6'd0, prog_en_even, prog_en_odd}, 8'h01);

    for (int i = 0; i < 3000; i++) begin
      cs_n     = ($urandom % 4) == 0;
      sel_prog = $urandom % 2;
      sel_data = $urandom % 2;
      bus8     = $urandom % 2;
      addr0    = $urandom % 2;
      reg_we   = ($urandom % 16) == 0;
      reg_wdata = 8'($urandom);
      if (($urandom % 30) == 0) logic_in = 16'($urandom);
      step();
    end
    reg_we = 1'b0;
    finish_run();
  end
endmodule